// File: doc/BRIEF.md
# Fault Status Register Bank

This block is a small bank of memory-mapped registers that holds the core's trap configuration and the record of faults it has taken. Software reaches the bank through a simple 32-bit register bus made of an address, a write strobe with write data, and a read strobe with registered read data. The core reports new faults through three 32-bit set-pulse vectors, one per status register. Any bit raised on one of these vectors becomes sticky until software clears it.

The map uses three access types. The configuration word is read/write but keeps only six trap and enable fields, and those fields also drive dedicated output pins. The three fault status words are sticky: hardware sets their bits, and software clears a bit by writing a 1 to it. Two fault address words capture whatever value is written to them. The map also holds an auxiliary status word that always reads zero and a read-only feature word. The decode is on the full byte address, so any address not listed below, including a misaligned one, is unmapped.

Top module: `fault_status_bank`

## Requirements
- R1: On synchronous active-high reset every register clears to zero, every configuration output is low, and the read data is zero.
- R2: A write to 0x0D14 stores only the bits in mask 0x0000031B, and the other bits read as zero. The kept fields are bit 0 (thread mode from any level), bit 1 (user set-pending), bit 3 (unaligned trap), bit 4 (divide-by-zero trap), bit 8 (bus-fault ignore at high priority) and bit 9 (stack alignment). Each kept field drives its own output pin.
- R3: At 0x0D28 (configurable fault status), 0x0D2C (hard fault status) and 0x0D30 (debug fault status), writing a 1 to a bit clears that bit and writing a 0 leaves it unchanged.
- R4: Each bit of a status register's set-pulse vector sets that bit in the cycle it is sampled. If a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R5: 0x0D34 (memory-management fault address) and 0x0D38 (bus fault address) store the full 32-bit value written and return it on read.
- R6: 0x0D3C (auxiliary fault status) always reads zero and ignores writes.
- R7: 0x0D40 is read-only and always returns 0x00000030.
- R8: A read of an unmapped address returns zero, and a write to one changes no register.
- R9: Read data appears in the cycle after the read strobe and is zero after a cycle with no read. A read and a write to the same address in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cfg_fault_set | input | 32 | Set pulses for the configurable fault status word |
| hard_fault_set | input | 32 | Set pulses for the hard fault status word |
| dbg_fault_set | input | 32 | Set pulses for the debug fault status word |
| cfg_thread_any | output | 1 | Configuration bit 0 |
| cfg_user_pend | output | 1 | Configuration bit 1 |
| cfg_unalign_trap | output | 1 | Configuration bit 3 |
| cfg_div0_trap | output | 1 | Configuration bit 4 |
| cfg_bf_ignore | output | 1 | Configuration bit 8 |
| cfg_stack_align | output | 1 | Configuration bit 9 |

## Verification
The configuration word is written with all ones, which shows that the mask drops reserved bits, and then with a sparse pattern, which shows that each kept field reaches its own pin. The sticky words take a checkerboard of set pulses and then partial clears. A write of zero tells a correct write-one-to-clear apart from a plain store, and a same-cycle set and clear on one bit shows that the set wins. The address words take two unrelated full-width values, which catches a truncated or swapped capture. All-ones writes to the auxiliary word, the feature word and several unmapped addresses show that these writes touch nothing. A read issued together with a write then shows the ordering between the two.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    parameter int ADDR_W = 12;
    parameter int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CFG  = 12'hD14;
    localparam logic [ADDR_W-1:0] A_CFS  = 12'hD28;
    localparam logic [ADDR_W-1:0] A_HFS  = 12'hD2C;
    localparam logic [ADDR_W-1:0] A_DFS  = 12'hD30;
    localparam logic [ADDR_W-1:0] A_MMA  = 12'hD34;
    localparam logic [ADDR_W-1:0] A_BFA  = 12'hD38;
    localparam logic [ADDR_W-1:0] A_AUX  = 12'hD3C;
    localparam logic [ADDR_W-1:0] A_FEAT = 12'hD40;

    localparam logic [DATA_W-1:0] CFG_MASK  = 32'h0000_031B;
    localparam logic [DATA_W-1:0] FEAT_WORD = 32'h0000_0030;

    localparam int N_STAT = 3;
    localparam int N_CAPT = 2;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_CFS,
        SEL_HFS,
        SEL_DFS,
        SEL_MMA,
        SEL_BFA,
        SEL_AUX,
        SEL_FEAT
    } reg_sel_e;

    typedef struct packed {
        logic stack_align;
        logic bf_ignore;
        logic div0_trap;
        logic unalign_trap;
        logic user_pend;
        logic thread_any;
    } cfg_fields_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            A_CFG:   s = SEL_CFG;
            A_CFS:   s = SEL_CFS;
            A_HFS:   s = SEL_HFS;
            A_DFS:   s = SEL_DFS;
            A_MMA:   s = SEL_MMA;
            A_BFA:   s = SEL_BFA;
            A_AUX:   s = SEL_AUX;
            A_FEAT:  s = SEL_FEAT;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic cfg_fields_t unpack_cfg(input logic [DATA_W-1:0] w);
        cfg_fields_t f;
        f.thread_any   = w[0];
        f.user_pend    = w[1];
        f.unalign_trap = w[3];
        f.div0_trap    = w[4];
        f.bf_ignore    = w[8];
        f.stack_align  = w[9];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cfg(input cfg_fields_t f);
        logic [DATA_W-1:0] w;
        w    = '0;
        w[0] = f.thread_any;
        w[1] = f.user_pend;
        w[3] = f.unalign_trap;
        w[4] = f.div0_trap;
        w[8] = f.bf_ignore;
        w[9] = f.stack_align;
        return w;
    endfunction

    function automatic reg_sel_e stat_sel(input int idx);
        reg_sel_e s;
        case (idx)
            0:       s = SEL_CFS;
            1:       s = SEL_HFS;
            default: s = SEL_DFS;
        endcase
        return s;
    endfunction

    function automatic reg_sel_e capt_sel(input int idx);
        return (idx == 0) ? SEL_MMA : SEL_BFA;
    endfunction

endpackage

// File: rtl/fsr_decode.sv
module fsr_decode
    import fsr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output bus_req_t          req
);
    always_comb begin
        req.wr    = wr;
        req.rd    = rd;
        req.sel   = decode_addr(addr);
        req.wdata = wdata;
    end
endmodule

// File: rtl/fsr_cfg_reg.sv
module fsr_cfg_reg
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output cfg_fields_t       fields,
    output logic [DATA_W-1:0] word
);
    cfg_fields_t f_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else if (we) begin
            f_q <= unpack_cfg(wdata & CFG_MASK);
        end
    end

    assign fields = f_q;
    assign word   = pack_cfg(f_q);
endmodule

// File: rtl/fsr_w1c_reg.sv
module fsr_w1c_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_bits,
    input  logic [WIDTH-1:0] set_bits,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] clr_eff;

    always_comb clr_eff = clr_en ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= (q & ~clr_eff) | set_bits;
        end
    end
endmodule

// File: rtl/fsr_hold_reg.sv
module fsr_hold_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/fsr_readback.sv
module fsr_readback
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] cfg_word,
    input  logic [DATA_W-1:0] cfs_word,
    input  logic [DATA_W-1:0] hfs_word,
    input  logic [DATA_W-1:0] dfs_word,
    input  logic [DATA_W-1:0] mma_word,
    input  logic [DATA_W-1:0] bfa_word,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mux_val;

    always_comb begin
        case (sel)
            SEL_CFG:  mux_val = cfg_word;
            SEL_CFS:  mux_val = cfs_word;
            SEL_HFS:  mux_val = hfs_word;
            SEL_DFS:  mux_val = dfs_word;
            SEL_MMA:  mux_val = mma_word;
            SEL_BFA:  mux_val = bfa_word;
            SEL_FEAT: mux_val = FEAT_WORD;
            default:  mux_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= rd ? mux_val : '0;
        end
    end
endmodule

// File: rtl/fault_status_bank.sv
module fault_status_bank
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] cfg_fault_set,
    input  logic [DATA_W-1:0] hard_fault_set,
    input  logic [DATA_W-1:0] dbg_fault_set,
    output logic              cfg_thread_any,
    output logic              cfg_user_pend,
    output logic              cfg_unalign_trap,
    output logic              cfg_div0_trap,
    output logic              cfg_bf_ignore,
    output logic              cfg_stack_align
);
    bus_req_t          req;
    cfg_fields_t       cfg_f;
    logic [DATA_W-1:0] cfg_word;
    logic [DATA_W-1:0] stat_set [N_STAT];
    logic [DATA_W-1:0] stat_q   [N_STAT];
    logic [DATA_W-1:0] capt_q   [N_CAPT];

    logic [DATA_W-1:0] cfs_q, hfs_q, dfs_q, mma_q, bfa_q;

    fsr_decode u_dec (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .wdata (bus_wdata),
        .req   (req)
    );

    fsr_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (req.wr && req.sel == SEL_CFG),
        .wdata  (req.wdata),
        .fields (cfg_f),
        .word   (cfg_word)
    );

    assign stat_set[0] = cfg_fault_set;
    assign stat_set[1] = hard_fault_set;
    assign stat_set[2] = dbg_fault_set;

    generate
        for (genvar i = 0; i < N_STAT; i++) begin : g_stat
            fsr_w1c_reg #(.WIDTH(DATA_W)) u_st (
                .clk      (clk),
                .rst      (rst),
                .clr_en   (req.wr && req.sel == stat_sel(i)),
                .clr_bits (req.wdata),
                .set_bits (stat_set[i]),
                .q        (stat_q[i])
            );
        end
        for (genvar j = 0; j < N_CAPT; j++) begin : g_capt
            fsr_hold_reg #(.WIDTH(DATA_W)) u_cap (
                .clk   (clk),
                .rst   (rst),
                .we    (req.wr && req.sel == capt_sel(j)),
                .wdata (req.wdata),
                .q     (capt_q[j])
            );
        end
    endgenerate

    assign cfs_q = stat_q[0];
    assign hfs_q = stat_q[1];
    assign dfs_q = stat_q[2];
    assign mma_q = capt_q[0];
    assign bfa_q = capt_q[1];

    fsr_readback u_rb (
        .clk      (clk),
        .rst      (rst),
        .rd       (req.rd),
        .sel      (req.sel),
        .cfg_word (cfg_word),
        .cfs_word (cfs_q),
        .hfs_word (hfs_q),
        .dfs_word (dfs_q),
        .mma_word (mma_q),
        .bfa_word (bfa_q),
        .rdata    (bus_rdata)
    );

    assign cfg_thread_any   = cfg_f.thread_any;
    assign cfg_user_pend    = cfg_f.user_pend;
    assign cfg_unalign_trap = cfg_f.unalign_trap;
    assign cfg_div0_trap    = cfg_f.div0_trap;
    assign cfg_bf_ignore    = cfg_f.bf_ignore;
    assign cfg_stack_align  = cfg_f.stack_align;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] hard_fault_set,
    input logic [DATA_W-1:0] hfs_q,
    input logic [DATA_W-1:0] cfs_q,
    input logic [DATA_W-1:0] cfg_fault_set,
    input logic [DATA_W-1:0] mma_q,
    input logic              cfg_unalign_trap,
    input logic              cfg_stack_align
);
    // R9
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));

    // R2
    cfg_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_CFG) |=> ((bus_rdata & ~CFG_MASK) == '0));

    // R2
    cfg_pin_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CFG) |=>
            (cfg_unalign_trap == $past(bus_wdata[3]) && cfg_stack_align == $past(bus_wdata[9])));

    // R7
    feat_const_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_FEAT) |=> (bus_rdata == FEAT_WORD));

    // R6
    aux_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_AUX) |=> (bus_rdata == '0));

    // R5
    mma_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_MMA) |=> (mma_q == $past(bus_wdata)));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_fault_set != '0) |=> ((cfs_q & $past(cfg_fault_set)) == $past(cfg_fault_set)));

    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        (hard_fault_set == '0) |=> ((hfs_q & ~$past(hfs_q)) == '0));
endmodule

bind fault_status_bank fsr_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .bus_addr         (bus_addr),
    .bus_wr           (bus_wr),
    .bus_wdata        (bus_wdata),
    .bus_rd           (bus_rd),
    .bus_rdata        (bus_rdata),
    .hard_fault_set   (hard_fault_set),
    .hfs_q            (hfs_q),
    .cfs_q            (cfs_q),
    .cfg_fault_set    (cfg_fault_set),
    .mma_q            (mma_q),
    .cfg_unalign_trap (cfg_unalign_trap),
    .cfg_stack_align  (cfg_stack_align)
);

// File: tb/sim_fault_status_bank.sv
module sim_fault_status_bank;
    import fsr_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic [DATA_W-1:0] cfg_fault_set = '0;
    logic [DATA_W-1:0] hard_fault_set = '0;
    logic [DATA_W-1:0] dbg_fault_set = '0;
    logic cfg_thread_any, cfg_user_pend, cfg_unalign_trap;
    logic cfg_div0_trap, cfg_bf_ignore, cfg_stack_align;

    always #4 clk = ~clk;

    fault_status_bank u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cfg_fault_set(cfg_fault_set), .hard_fault_set(hard_fault_set),
        .dbg_fault_set(dbg_fault_set), .cfg_thread_any(cfg_thread_any),
        .cfg_user_pend(cfg_user_pend), .cfg_unalign_trap(cfg_unalign_trap),
        .cfg_div0_trap(cfg_div0_trap), .cfg_bf_ignore(cfg_bf_ignore),
        .cfg_stack_align(cfg_stack_align)
    );

    typedef struct {
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    logic rd_seen = 1'b0;

    logic [31:0] m_cfg, m_cfs, m_hfs, m_dfs, m_mma, m_bfa;

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            12'hD14: return m_cfg;
            12'hD28: return m_cfs;
            12'hD2C: return m_hfs;
            12'hD30: return m_dfs;
            12'hD34: return m_mma;
            12'hD38: return m_bfa;
            12'hD40: return 32'h0000_0030;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cfg = 0; m_cfs = 0; m_hfs = 0; m_dfs = 0; m_mma = 0; m_bfa = 0;
    endtask

    // one bus cycle with optional write, read and set pulses
    task automatic step(input logic wr, input logic rd, input logic [11:0] a,
                        input logic [31:0] wd, input logic [31:0] sc,
                        input logic [31:0] sh, input logic [31:0] sd,
                        input string tag);
        exp_t e;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        cfg_fault_set = sc; hard_fault_set = sh; dbg_fault_set = sd;
        if (rd) begin
            e.data = model_read(a);
            e.tag  = tag;
            exp_q.push_back(e);
        end
        if (wr) begin
            case (a)
                12'hD14: m_cfg = wd & 32'h0000_031B;
                12'hD28: m_cfs = m_cfs & ~wd;
                12'hD2C: m_hfs = m_hfs & ~wd;
                12'hD30: m_dfs = m_dfs & ~wd;
                12'hD34: m_mma = wd;
                12'hD38: m_bfa = wd;
                default: ;
            endcase
        end
        m_cfs = m_cfs | sc;
        m_hfs = m_hfs | sh;
        m_dfs = m_dfs | sd;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b0, a, d, 0, 0, 0, tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        step(1'b0, 1'b1, a, 0, 0, 0, 0, tag);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 12'h0, 0, 0, 0, 0, "idle");
    endtask

    task automatic check_pins(input string tag);
        check({26'h0, cfg_stack_align, cfg_bf_ignore, cfg_div0_trap,
               cfg_unalign_trap, cfg_user_pend, cfg_thread_any},
              {26'h0, m_cfg[9], m_cfg[8], m_cfg[4], m_cfg[3], m_cfg[1], m_cfg[0]}, tag);
    endtask

    task automatic read_all(input string tag);
        rd(12'hD14, tag); rd(12'hD28, tag); rd(12'hD2C, tag); rd(12'hD30, tag);
        rd(12'hD34, tag); rd(12'hD38, tag); rd(12'hD3C, tag); rd(12'hD40, tag);
        idle(); idle();
    endtask

    always @(posedge clk) rd_seen <= bus_rd && !rst;

    // monitor: compare registered read data against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_seen) begin
                if (exp_q.size() == 0) begin
                    check(bus_rdata, 32'hx, "R9 unexpected read result");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(bus_rdata, e.data, e.tag);
                end
            end else begin
                check(bus_rdata, 32'h0, "R9 idle read data zero");
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(bus_rdata, 0, "R1 rdata after reset");
        check_pins("R1 config pins after reset");
        read_all("R1 R7 reset readback");

        // R2 masked configuration
        wr(12'hD14, 32'hFFFF_FFFF, "R2");
        idle();
        check_pins("R2 pins all-ones write");
        rd(12'hD14, "R2 mask all ones");
        wr(12'hD14, 32'h0000_0208, "R2");
        idle();
        check_pins("R2 pins sparse write");
        rd(12'hD14, "R2 sparse readback");

        // R3 R4 sticky status
        step(0, 0, 0, 0, 32'hA5A5_0F0F, 32'h4000_0002, 32'h0000_001F, "R4");
        idle();
        rd(12'hD28, "R4 set pulses cfs");
        rd(12'hD2C, "R4 set pulses hfs");
        rd(12'hD30, "R4 set pulses dfs");
        wr(12'hD28, 32'h0000_000F, "R3");
        rd(12'hD28, "R3 partial clear cfs");
        wr(12'hD30, 32'h0, "R3");
        rd(12'hD30, "R3 zero write keeps dfs");
        wr(12'hD30, 32'h0000_0005, "R3");
        rd(12'hD30, "R3 clear dfs bits");
        step(1, 0, 12'hD2C, 32'h0000_0002, 0, 32'h0000_0002, 0, "R4");
        rd(12'hD2C, "R4 set beats clear");
        wr(12'hD2C, 32'hFFFF_FFFF, "R3");
        rd(12'hD2C, "R3 clear all hfs");

        // R5 address capture
        wr(12'hD34, 32'hDEAD_BEEF, "R5");
        wr(12'hD38, 32'h1234_5678, "R5");
        rd(12'hD34, "R5 mm address");
        rd(12'hD38, "R5 bus address");

        // R6 R7 constant words
        wr(12'hD3C, 32'hFFFF_FFFF, "R6");
        rd(12'hD3C, "R6 aux reads zero");
        wr(12'hD40, 32'h0, "R7");
        rd(12'hD40, "R7 feature word");

        // R8 unmapped
        wr(12'hD18, 32'hFFFF_FFFF, "R8");
        wr(12'hD20, 32'hFFFF_FFFF, "R8");
        wr(12'h000, 32'hFFFF_FFFF, "R8");
        wr(12'hD35, 32'hFFFF_FFFF, "R8");
        rd(12'hD18, "R8 unmapped read");
        rd(12'hFFC, "R8 unmapped read");
        read_all("R8 map unchanged");

        // R9 read during write returns old value
        step(1, 1, 12'hD34, 32'h0BAD_F00D, 0, 0, 0, "R9 read-with-write old");
        rd(12'hD34, "R9 new value next read");
        idle(); idle();

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_pins("R1 pins after second reset");
        read_all("R1 all zero after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule